// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a binary up-counter built from a parameter-set number of identical 4-bit stages that share one clock. Each stage has an active-low synchronous clear, an active-low synchronous parallel load, and two count enables. One enable is shared by every stage. The other is a look-ahead enable that each stage passes on to the next through its terminal-count flag. Chained this way, the stages count exactly like a single wide counter of 4×STAGES bits.

The clear has the highest priority, then the load, then the increment, then the hold. Nothing acts between clock edges. A build-time option adds a decoder that watches the count for a chosen last value and pulls the internal clear low when it sees it. This shortens the counting cycle to that value plus one. The block has no streaming data path: every pin is a plain level-sensitive control or status signal sampled on the rising clock edge, so no valid/ready handshake or back-pressure applies.

Top module: `casc_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `count` becomes 0 after that edge, whatever the levels on `load_n`, `cnt_en_p` and `cnt_en_t`.
- R2: When `clr_n` is 1, no truncation clear is pending and `load_n` is 0 at a rising edge, `count` takes the value of `din` after that edge, whatever the levels on the two enables.
- R3: When `clr_n` and `load_n` are both 1 and `cnt_en_p` and `cnt_en_t` are both 1, `count` increases by one at the edge, and the all-ones value wraps to 0.
- R4: When `clr_n` and `load_n` are both 1 and either enable is 0, `count` holds its value.
- R5: `term_cnt` is 1 exactly when `cnt_en_t` is 1 and every bit of `count` is 1. It follows these signals within the same cycle, and `cnt_en_p` has no effect on it.
- R6: A 4-bit stage above the lowest one advances only when all lower stages are at all ones, so a carry passes across stage boundaries in a single edge (for example 0x0FF to 0x100).
- R7: With TRUNC_EN set, a `count` equal to MOD_LAST at a rising edge forces `count` to 0 after that edge, even with load or enables active. The counting cycle is then MOD_LAST+1 states long.
- R8: A change on `clr_n` or `load_n` between rising edges has no effect on `count` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all stages |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | 4×STAGES | Value copied into the counter on a load |
| cnt_en_p | input | 1 | Count enable shared by all stages; does not gate the terminal flag |
| cnt_en_t | input | 1 | Look-ahead count enable; also gates the terminal flag |
| count | output | 4×STAGES | Current counter value |
| term_cnt | output | 1 | High when `cnt_en_t` is high and the count is all ones |

## Verification
The bench loads values just below stage boundaries and counts through them. A stage that took its enable from the wrong neighbour, or that carried one edge late, would land on 0x0F0 or 0x1FF instead of 0x100. It holds the count at all ones while dropping the shared enable. A terminal flag wrongly gated by that enable would then go low, and dropping the look-ahead enable must take the flag low at once. It also asserts clear together with load and both enables, and asserts load with both enables low, so a design with the wrong priority order, or one that lets the enables gate the load, loads, counts or holds instead. A second, truncated instance is driven into its last value while loads and enables are active. A decoder that was missing, or that waited for an enable, would run past that value or load instead of returning to 0.

// File: rtl/casc_cnt_pkg.sv
package casc_cnt_pkg;

  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_INC   = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } stage_act_e;

  // Priority: clear, then load, then increment, then hold.
  function automatic stage_act_e pick_act(input logic clr_n, input logic load_n,
                                          input logic en_p, input logic en_t);
    if (!clr_n)           return ACT_CLEAR;
    else if (!load_n)     return ACT_LOAD;
    else if (en_p && en_t) return ACT_INC;
    else                  return ACT_HOLD;
  endfunction

endpackage

// File: rtl/casc_cnt_stage.sv
module casc_cnt_stage
  import casc_cnt_pkg::*;
#(
  parameter int unsigned SW = NIB_W
) (
  input  logic          clk,
  input  logic          clr_n,
  input  logic          load_n,
  input  logic [SW-1:0] d,
  input  logic          en_p,
  input  logic          en_t,
  output logic [SW-1:0] q,
  output logic          tc
);

  stage_act_e act;
  logic [SW-1:0] q_next;

  always_comb begin
    act = pick_act(clr_n, load_n, en_p, en_t);
    unique case (act)
      ACT_CLEAR: q_next = '0;
      ACT_LOAD:  q_next = d;
      ACT_INC:   q_next = q + 1'b1;
      default:   q_next = q;
    endcase
  end

  always_ff @(posedge clk) begin
    q <= q_next;
  end

  // Look-ahead carry: gated only by the ripple enable.
  assign tc = en_t & (&q);

endmodule

// File: rtl/casc_cnt_trunc.sv
module casc_cnt_trunc #(
  parameter int unsigned W        = 8,
  parameter bit          TRUNC_EN = 1'b0,
  parameter int unsigned MOD_LAST = 0
) (
  input  logic [W-1:0] count,
  input  logic         clr_n_in,
  output logic         clr_n_out
);

  generate
    if (TRUNC_EN) begin : g_decode
      localparam logic [W-1:0] LAST_VAL = W'(MOD_LAST);
      logic hit_n;
      // NAND-style decode: low when the last value is present.
      assign hit_n     = ~(count == LAST_VAL);
      assign clr_n_out = clr_n_in & hit_n;
    end else begin : g_pass
      logic unused_count;
      assign unused_count = ^count;
      assign clr_n_out    = clr_n_in;
    end
  endgenerate

endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import casc_cnt_pkg::*;
#(
  parameter int unsigned STAGES   = 3,
  parameter bit          TRUNC_EN = 1'b0,
  parameter int unsigned MOD_LAST = 0
) (
  input  logic                    clk,
  input  logic                    clr_n,
  input  logic                    load_n,
  input  logic [NIB_W*STAGES-1:0] din,
  input  logic                    cnt_en_p,
  input  logic                    cnt_en_t,
  output logic [NIB_W*STAGES-1:0] count,
  output logic                    term_cnt
);

  localparam int unsigned W = NIB_W * STAGES;

  logic              clr_n_eff;
  logic [STAGES:0]   en_chain;

  casc_cnt_trunc #(
    .W        (W),
    .TRUNC_EN (TRUNC_EN),
    .MOD_LAST (MOD_LAST)
  ) u_trunc (
    .count     (count),
    .clr_n_in  (clr_n),
    .clr_n_out (clr_n_eff)
  );

  assign en_chain[0] = cnt_en_t;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      casc_cnt_stage #(.SW(NIB_W)) u_stage (
        .clk    (clk),
        .clr_n  (clr_n_eff),
        .load_n (load_n),
        .d      (din[s*NIB_W +: NIB_W]),
        .en_p   (cnt_en_p),
        .en_t   (en_chain[s]),
        .q      (count[s*NIB_W +: NIB_W]),
        .tc     (en_chain[s+1])
      );
    end
  endgenerate

  assign term_cnt = en_chain[STAGES];

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int unsigned W        = 12,
  parameter bit          TRUNC_EN = 1'b0,
  parameter int unsigned MOD_LAST = 0
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic [W-1:0] din,
  input logic         cnt_en_p,
  input logic         cnt_en_t,
  input logic [W-1:0] count,
  input logic         term_cnt
);

  localparam logic [W-1:0] LAST_VAL = W'(MOD_LAST);

  // Count is undefined until the first clear edge has passed.
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | ~clr_n;

  logic hit;
  assign hit = TRUNC_EN && (count == LAST_VAL);

  p_clear_r1: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> count == '0);

  p_load_r2: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !load_n && !hit) |=> count == $past(din));

  p_inc_wrap_r3: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && cnt_en_p && cnt_en_t && !hit) |=> count == W'($past(count) + 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && load_n && !(cnt_en_p && cnt_en_t) && !hit) |=> $stable(count));

  p_tc_only_r5: assert property (@(posedge clk) disable iff (!armed)
    term_cnt |-> (cnt_en_t && (&count)));

  p_tc_live_r5: assert property (@(posedge clk) disable iff (!armed)
    (cnt_en_t && (&count)) |-> term_cnt);

  p_trunc_r7: assert property (@(posedge clk) disable iff (!armed)
    hit |=> count == '0);

endmodule

bind casc_counter casc_counter_chk #(
  .W        (W),
  .TRUNC_EN (TRUNC_EN),
  .MOD_LAST (MOD_LAST)
) u_chk (
  .clk      (clk),
  .clr_n    (clr_n),
  .load_n   (load_n),
  .din      (din),
  .cnt_en_p (cnt_en_p),
  .cnt_en_t (cnt_en_t),
  .count    (count),
  .term_cnt (term_cnt)
);

// File: tb/casc_counter_bench.sv
`timescale 1ns/1ps
module casc_counter_bench;

  localparam int ST  = 3;
  localparam int W   = 12;
  localparam int ST2 = 2;
  localparam int W2  = 8;
  localparam int ML  = 199;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          clr_n = 1'b1, load_n = 1'b1, cep = 1'b0, cet = 1'b0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  cnt1;
  logic [W2-1:0] cnt2;
  logic          tc1, tc2;

  casc_counter #(.STAGES(ST)) u_casc_counter (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .cnt_en_p(cep), .cnt_en_t(cet), .count(cnt1), .term_cnt(tc1));

  casc_counter #(.STAGES(ST2), .TRUNC_EN(1'b1), .MOD_LAST(ML)) u_casc_counter_mod (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din[W2-1:0]),
    .cnt_en_p(cep), .cnt_en_t(cet), .count(cnt2), .term_cnt(tc2));

  int n_cmp = 0, n_bad = 0;
  int exp1 = 0, exp2 = 0;
  string tag1 = "R1", tag2 = "R1";
  bit valid = 1'b0;

  task automatic chk(string rq, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int nxt(int cur, int w, bit tr, int ml, logic c, logic l,
                             logic p, logic t, int d, output string tg);
    int mask = (1 << w) - 1;
    if (!c) begin tg = "R1"; return 0; end
    if (tr && cur == ml) begin tg = "R7"; return 0; end
    if (!l) begin tg = "R2"; return d & mask; end
    if (p && t) begin
      if (cur != mask && (cur & 15) == 15) tg = "R6";
      else tg = "R3";
      return (cur + 1) & mask;
    end
    tg = "R4";
    return cur;
  endfunction

  function automatic int tcx(int cur, int w, logic t);
    return (t && cur == ((1 << w) - 1)) ? 1 : 0;
  endfunction

  task automatic apply(logic c, logic l, logic p, logic t, int d);
    clr_n = c; load_n = l; cep = p; cet = t; din = W'(d);
    #1;
    if (valid) begin
      chk("R5", int'(tc1), tcx(exp1, W, t));
      chk("R5", int'(tc2), tcx(exp2, W2, t));
    end
    exp1 = nxt(exp1, W, 1'b0, 0, c, l, p, t, d, tag1);
    exp2 = nxt(exp2, W2, 1'b1, ML, c, l, p, t, d, tag2);
    valid = 1'b1;
  endtask

  task automatic cyc(logic c, logic l, logic p, logic t, int d);
    @(negedge clk);
    if (valid) begin
      chk(tag1, int'(cnt1), exp1);
      chk(tag2, int'(cnt2), exp2);
    end
    apply(c, l, p, t, d);
  endtask

  // R8: pulse clear and load between edges, release before the edge.
  task automatic glitch_cyc();
    @(negedge clk);
    chk(tag1, int'(cnt1), exp1);
    chk(tag2, int'(cnt2), exp2);
    clr_n = 1'b0; load_n = 1'b0;
    #3;
    chk("R8", int'(cnt1), exp1);
    chk("R8", int'(cnt2), exp2);
    apply(1'b1, 1'b1, 1'b0, 1'b1, 0);
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd24601));
    cyc(1'b0, 1'b1, 1'b1, 1'b1, 0);          // reset state, R1
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 0);          // hold at 0, R4
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 'h0FE);      // load
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 0); // R6 carry 0x0FF->0x100
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 'hFFF);      // R2 load with enables low
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 0);          // R5 tc high while cep low
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 0);          // R5 tc low with cet low, R4 hold
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 0);          // R3 wrap
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 'h5A5);      // R1 overrides load/enables
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 197);        // truncated instance near its end
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1, 0); // R7 199 -> 0
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 199);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 'h3C7);      // R7 at 199 with load active
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 0);
    glitch_cyc();
    glitch_cyc();
    for (int i = 0; i < 4000; i++) begin
      logic c, l, p, t;
      int d;
      c = ($urandom % 25) != 0;
      l = ($urandom % 12) != 0;
      p = ($urandom % 6) != 0;
      t = ($urandom % 6) != 0;
      case ($urandom % 4)
        0:       d = 'hFF0 | ($urandom % 16);
        1:       d = (($urandom % 16) << 8) | 'hF0 | ($urandom % 16);
        2:       d = 190 + ($urandom % 10);
        default: d = $urandom % 4096;
      endcase
      if (i % 97 == 50) glitch_cyc();
      else cyc(c, l, p, t, d);
    end
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 0);
    @(negedge clk);
    chk(tag1, int'(cnt1), exp1);
    chk(tag2, int'(cnt2), exp2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule